// File: doc/BRIEF.md
# Per-CPU Aliased Interrupt Controller Register Window

This block is the register front end of a multi-processor interrupt controller. It decodes single-word reads and writes from a simple memory-mapped bus. Each request carries the index of the CPU that issued it. The block holds the controller's global registers and one small private register bank per CPU.

A CPU's bank can be reached in two ways. The first is an explicit per-CPU region, where address bits pick the CPU. The second is a shadow window in global space, which resolves to the bank of whichever CPU made the access. Every CPU can therefore reach its own private registers at one common address.

Writes to the dispatch slots of a bank raise a one-cycle inter-processor interrupt request. Writes to the global configuration word can request a controller reset. A processor-init mask drives one reset line per CPU.

Address layout (18-bit byte address): bit 17 = 0 selects global space, with the offset in bits [12:0] and bits [16:13] required to be zero. Bit 17 = 1 selects the explicit per-CPU region: bits [16:12] give the CPU index and bits [11:0] give the offset within that CPU's bank.

Top module: `pic_regwin`

## Requirements
- R1: An access with a nonzero address bits [3:0] is misaligned. Writing it changes no register and raises no output. Reading it returns 0xFFFFFFFF.
- R2: An aligned access to an offset that maps to no register returns 0xFFFFFFFF on read and has no effect on write. This includes a bank access whose decoded CPU index is NUM_CPU or greater, and any global address with bits [16:13] nonzero.
- R3: A read request gets `rsp_valid` high for exactly the next cycle, with the data in `rsp_rdata`. A write request produces no `rsp_valid`.
- R4: In the explicit region (bit 17 = 1), bank offsets 0x40 through 0xB0 reach the bank of the CPU in bits [16:12].
- R5: Global offsets 0x040 through 0x0B0 form a shadow window onto the same bank offsets of the CPU given by `req_cpu`.
- R6: Global 0x1000 is a read-only feature word equal to ((NUM_CPU-1) << 8) | 0x04. Global 0x1080 is a read-only vendor word equal to VENDOR_ID (default 0x00010002). Writes to either are ignored.
- R7: Global 0x1020 (configuration) stores the written word with bit 31 cleared. A write with bit 31 set makes `ctrl_reset` high for exactly the one cycle after the write.
- R8: Global 0x1090 (processor init) always reads 0. When a write takes bit i from 0 to 1, `cpu_reset[i]` rises on the next cycle. It stays high until a write clears bit i.
- R9: Global 0x10E0 (spurious vector) keeps only the low 8 bits of a write and reads them zero-extended. Global 0x10F0 (timer frequency) is a full 32-bit register.
- R10: Global 0x10A0, 0x10B0, 0x10C0 and 0x10D0 are four 32-bit IPI vector/priority words, indexed 0 to 3 in that order.
- R11: A write to bank offset 0x40 + 0x10*n (n = 0..3) pulses `ipi_valid` for one cycle, the cycle after the write. In that cycle `ipi_num` = n, `ipi_src` = the bank's CPU and `ipi_dest` = the written data bits [NUM_CPU-1:0]. These offsets read as 0.
- R12: Bank offset 0x80 is a 4-bit priority read zero-extended. Offset 0x90 is read-only and returns the bank's CPU index. Offsets 0xA0 and 0xB0 are 32-bit scratch words.
- R13: Reset values:
  - configuration, timer frequency, priority-init mask and scratch words: 0
  - spurious vector: 0xFF
  - IPI vector/priority words: 0x80000000
  - bank priority: 0xF
  - all outputs low

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_cpu | input | 5 | Index of the requesting CPU |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| ctrl_reset | output | 1 | One-cycle controller reset request |
| cpu_reset | output | NUM_CPU | Per-CPU reset lines |
| ipi_valid | output | 1 | IPI dispatch strobe |
| ipi_src | output | 5 | CPU whose bank was written |
| ipi_num | output | 2 | IPI index |
| ipi_dest | output | NUM_CPU | Destination CPU mask |

## Verification
The assertions assume the bus inputs hold known values in every cycle after reset. They also assume at most one request is presented per cycle, so no more than one bank can fire an IPI at a time. The stimulus drives `req_valid` low between transactions and keeps every input defined. It draws `req_cpu` from a range that deliberately includes indices past NUM_CPU, so the out-of-range path is exercised without ever giving the bus an undefined requester.

// File: rtl/pic_regwin_pkg.sv
package pic_regwin_pkg;

    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 18;
    localparam int CPU_IDX_W  = 5;
    localparam int NUM_IPI    = 4;
    localparam int REGION_BIT = 17;
    localparam int SLOT_W     = 4;

    localparam logic [WORD_W-1:0] UNMAPPED_WORD = '1;

    // slot = bank offset >> 4
    localparam logic [SLOT_W-1:0] SLOT_IPI_LO = 4'd4;
    localparam logic [SLOT_W-1:0] SLOT_IPI_HI = 4'd7;
    localparam logic [SLOT_W-1:0] SLOT_PRIO   = 4'd8;
    localparam logic [SLOT_W-1:0] SLOT_WHO    = 4'd9;
    localparam logic [SLOT_W-1:0] SLOT_SCR_A  = 4'd10;
    localparam logic [SLOT_W-1:0] SLOT_SCR_B  = 4'd11;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_GLOBAL,
        TGT_BANK
    } tgt_e;

    typedef enum logic [2:0] {
        GR_FEATURE,
        GR_GCFG,
        GR_VENDOR,
        GR_PINIT,
        GR_IPIVP,
        GR_SPUR,
        GR_TFREQ
    } greg_e;

    typedef struct packed {
        tgt_e                 tgt;
        logic [CPU_IDX_W-1:0] cpu;
        logic [SLOT_W-1:0]    slot;
        greg_e                greg;
        logic [1:0]           ipivp_idx;
    } dec_t;

    function automatic logic in_bank_window(input logic [11:0] off);
        return (off >= 12'h040) && (off <= 12'h0B0);
    endfunction

    function automatic logic is_dispatch_slot(input logic [SLOT_W-1:0] s);
        return (s >= SLOT_IPI_LO) && (s <= SLOT_IPI_HI);
    endfunction

endpackage

// File: rtl/pic_regwin_decode.sv
module pic_regwin_decode
    import pic_regwin_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CPU_IDX_W-1:0] req_cpu,
    output dec_t                 dec
);

    logic aligned;
    logic cpu_field_ok;
    logic requester_ok;

    assign aligned      = (addr[3:0] == 4'h0);
    assign cpu_field_ok = (int'(addr[16:12]) < NUM_CPU);
    assign requester_ok = (int'(req_cpu) < NUM_CPU);

    always_comb begin
        dec.tgt       = TGT_NONE;
        dec.cpu       = '0;
        dec.slot      = addr[7:4];
        dec.greg      = GR_FEATURE;
        dec.ipivp_idx = addr[5:4] - 2'd2;
        if (aligned) begin
            if (addr[REGION_BIT]) begin
                // explicit per-CPU region
                if (cpu_field_ok && in_bank_window(addr[11:0])) begin
                    dec.tgt = TGT_BANK;
                    dec.cpu = addr[16:12];
                end
            end else if (addr[16:13] == 4'h0) begin
                if (!addr[12]) begin
                    // shadow window follows the requester
                    if (requester_ok && in_bank_window(addr[11:0])) begin
                        dec.tgt = TGT_BANK;
                        dec.cpu = req_cpu;
                    end
                end else if (addr[11:8] == 4'h0) begin
                    dec.tgt = TGT_GLOBAL;
                    unique case (addr[7:4])
                        4'h0:                   dec.greg = GR_FEATURE;
                        4'h2:                   dec.greg = GR_GCFG;
                        4'h8:                   dec.greg = GR_VENDOR;
                        4'h9:                   dec.greg = GR_PINIT;
                        4'hA, 4'hB, 4'hC, 4'hD: dec.greg = GR_IPIVP;
                        4'hE:                   dec.greg = GR_SPUR;
                        4'hF:                   dec.greg = GR_TFREQ;
                        default:                dec.tgt  = TGT_NONE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/pic_regwin_global.sv
module pic_regwin_global
    import pic_regwin_pkg::*;
#(
    parameter int                NUM_CPU   = 4,
    parameter logic [WORD_W-1:0] VENDOR_ID = 32'h0001_0002
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  greg_e              sel,
    input  logic [1:0]         ipivp_idx,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rdata,
    output logic               ctrl_reset,
    output logic [NUM_CPU-1:0] cpu_reset
);

    localparam logic [WORD_W-1:0] FEATURE_WORD = WORD_W'((NUM_CPU - 1) << 8) | 32'h0000_0004;
    localparam logic [WORD_W-1:0] IPIVP_RESET  = 32'h8000_0000;
    localparam logic [WORD_W-1:0] TOP_BIT      = 32'h8000_0000;

    logic [WORD_W-1:0]  gcfg_q;
    logic [WORD_W-1:0]  tfreq_q;
    logic [7:0]         spur_q;
    logic [NUM_CPU-1:0] pinit_q;
    logic [WORD_W-1:0]  ipivp_q [NUM_IPI];
    logic               crst_q;
    logic [NUM_CPU-1:0] pinit_new;

    assign pinit_new = wdata[NUM_CPU-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            gcfg_q  <= '0;
            tfreq_q <= '0;
            spur_q  <= 8'hFF;
            pinit_q <= '0;
            crst_q  <= 1'b0;
            for (int i = 0; i < NUM_IPI; i++) ipivp_q[i] <= IPIVP_RESET;
        end else begin
            crst_q <= 1'b0;
            if (wr_en) begin
                unique case (sel)
                    GR_GCFG: begin
                        gcfg_q <= wdata & ~TOP_BIT;
                        crst_q <= wdata[WORD_W-1];
                    end
                    // rising bits raise a line, cleared bits drop it
                    GR_PINIT: pinit_q <= (pinit_q | (pinit_new & ~pinit_q)) & pinit_new;
                    GR_IPIVP: ipivp_q[ipivp_idx] <= wdata;
                    GR_SPUR:  spur_q  <= wdata[7:0];
                    GR_TFREQ: tfreq_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (sel)
            GR_FEATURE: rdata = FEATURE_WORD;
            GR_GCFG:    rdata = gcfg_q;
            GR_VENDOR:  rdata = VENDOR_ID;
            GR_PINIT:   rdata = '0;
            GR_IPIVP:   rdata = ipivp_q[ipivp_idx];
            GR_SPUR:    rdata = {24'h0, spur_q};
            GR_TFREQ:   rdata = tfreq_q;
            default:    rdata = UNMAPPED_WORD;
        endcase
    end

    assign ctrl_reset = crst_q;
    assign cpu_reset  = pinit_q;

    // R7
    gcfg_reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_reset |-> $past(wr_en && sel == GR_GCFG && wdata[WORD_W-1]));

    // R8
    cpu_reset_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en && sel == GR_PINIT) |-> $stable(cpu_reset));

    // R9
    tfreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en && sel == GR_TFREQ) |-> $stable(tfreq_q));

endmodule

// File: rtl/pic_regwin_cpubank.sv
module pic_regwin_cpubank
    import pic_regwin_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_ID  = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rdata,
    output logic               ipi_fire,
    output logic [1:0]         ipi_num,
    output logic [NUM_CPU-1:0] ipi_dest
);

    logic [3:0]         prio_q;
    logic [WORD_W-1:0]  scr_a_q;
    logic [WORD_W-1:0]  scr_b_q;
    logic               fire_q;
    logic [1:0]         num_q;
    logic [NUM_CPU-1:0] dest_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q  <= 4'hF;
            scr_a_q <= '0;
            scr_b_q <= '0;
            fire_q  <= 1'b0;
            num_q   <= '0;
            dest_q  <= '0;
        end else begin
            fire_q <= 1'b0;
            if (wr_en) begin
                if (is_dispatch_slot(slot)) begin
                    fire_q <= 1'b1;
                    num_q  <= slot[1:0];
                    dest_q <= wdata[NUM_CPU-1:0];
                end else if (slot == SLOT_PRIO) begin
                    prio_q <= wdata[3:0];
                end else if (slot == SLOT_SCR_A) begin
                    scr_a_q <= wdata;
                end else if (slot == SLOT_SCR_B) begin
                    scr_b_q <= wdata;
                end
            end
        end
    end

    always_comb begin
        if (is_dispatch_slot(slot))  rdata = '0;
        else if (slot == SLOT_PRIO)  rdata = {28'h0, prio_q};
        else if (slot == SLOT_WHO)   rdata = WORD_W'(CPU_ID);
        else if (slot == SLOT_SCR_A) rdata = scr_a_q;
        else if (slot == SLOT_SCR_B) rdata = scr_b_q;
        else                         rdata = UNMAPPED_WORD;
    end

    assign ipi_fire = fire_q;
    assign ipi_num  = num_q;
    assign ipi_dest = dest_q;

    // R11
    ipi_from_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
        ipi_fire |-> $past(wr_en && is_dispatch_slot(slot)));

    // R12
    prio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en && slot == SLOT_PRIO) |-> $stable(prio_q));

endmodule

// File: rtl/pic_regwin.sv
module pic_regwin
    import pic_regwin_pkg::*;
#(
    parameter int                NUM_CPU   = 4,
    parameter logic [WORD_W-1:0] VENDOR_ID = 32'h0001_0002
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CPU_IDX_W-1:0] req_cpu,
    input  logic [WORD_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_rdata,
    output logic                 ctrl_reset,
    output logic [NUM_CPU-1:0]   cpu_reset,
    output logic                 ipi_valid,
    output logic [CPU_IDX_W-1:0] ipi_src,
    output logic [1:0]           ipi_num,
    output logic [NUM_CPU-1:0]   ipi_dest
);

    dec_t               dec;
    logic               glb_wr;
    logic [WORD_W-1:0]  glb_rdata;
    logic [WORD_W-1:0]  bank_rdata [NUM_CPU];
    logic [NUM_CPU-1:0] bank_fire;
    logic [1:0]         bank_num   [NUM_CPU];
    logic [NUM_CPU-1:0] bank_dest  [NUM_CPU];
    logic [WORD_W-1:0]  rd_mux;
    logic               rsp_valid_q;
    logic [WORD_W-1:0]  rsp_rdata_q;

    pic_regwin_decode #(.NUM_CPU(NUM_CPU)) u_decode (
        .addr    (req_addr),
        .req_cpu (req_cpu),
        .dec     (dec)
    );

    assign glb_wr = req_valid && req_write && (dec.tgt == TGT_GLOBAL);

    pic_regwin_global #(.NUM_CPU(NUM_CPU), .VENDOR_ID(VENDOR_ID)) u_global (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (glb_wr),
        .sel        (dec.greg),
        .ipivp_idx  (dec.ipivp_idx),
        .wdata      (req_wdata),
        .rdata      (glb_rdata),
        .ctrl_reset (ctrl_reset),
        .cpu_reset  (cpu_reset)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        logic bank_wr;
        assign bank_wr = req_valid && req_write && (dec.tgt == TGT_BANK)
                         && (dec.cpu == CPU_IDX_W'(c));
        pic_regwin_cpubank #(.NUM_CPU(NUM_CPU), .CPU_ID(c)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bank_wr),
            .slot     (dec.slot),
            .wdata    (req_wdata),
            .rdata    (bank_rdata[c]),
            .ipi_fire (bank_fire[c]),
            .ipi_num  (bank_num[c]),
            .ipi_dest (bank_dest[c])
        );
    end

    always_comb begin
        rd_mux = UNMAPPED_WORD;
        if (dec.tgt == TGT_GLOBAL) begin
            rd_mux = glb_rdata;
        end else if (dec.tgt == TGT_BANK) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                if (dec.cpu == CPU_IDX_W'(c)) rd_mux = bank_rdata[c];
            end
        end
    end

    always_comb begin
        ipi_valid = 1'b0;
        ipi_src   = '0;
        ipi_num   = '0;
        ipi_dest  = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (bank_fire[c]) begin
                ipi_valid = 1'b1;
                ipi_src   = CPU_IDX_W'(c);
                ipi_num   = bank_num[c];
                ipi_dest  = bank_dest[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= req_valid && !req_write;
            if (req_valid && !req_write) rsp_rdata_q <= rd_mux;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

    // R3
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R3
    rsp_only_for_read_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    // R1
    misaligned_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr[3:0] != 4'h0) |=> (rsp_rdata == UNMAPPED_WORD));

    // R11
    ipi_single_source_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_fire));

endmodule

// File: tb/sim_pic_regwin.sv
`timescale 1ns/1ps
module sim_pic_regwin;

    localparam int NCPU = 4;
    localparam logic [31:0] VID = 32'h0001_0002;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [4:0]  req_cpu = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        ctrl_reset;
    logic [NCPU-1:0] cpu_reset;
    logic        ipi_valid;
    logic [4:0]  ipi_src;
    logic [1:0]  ipi_num;
    logic [NCPU-1:0] ipi_dest;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pic_regwin #(.NUM_CPU(NCPU), .VENDOR_ID(VID)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_cpu(req_cpu), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ctrl_reset(ctrl_reset),
        .cpu_reset(cpu_reset), .ipi_valid(ipi_valid), .ipi_src(ipi_src),
        .ipi_num(ipi_num), .ipi_dest(ipi_dest)
    );

    // reference model state
    logic [31:0] m_gcfg, m_tfreq;
    logic [7:0]  m_spur;
    logic [NCPU-1:0] m_pinit;
    logic [31:0] m_ipivp [4];
    logic [3:0]  m_prio [NCPU];
    logic [31:0] m_sa [NCPU];
    logic [31:0] m_sb [NCPU];

    task automatic model_reset();
        m_gcfg = 0; m_tfreq = 0; m_spur = 8'hFF; m_pinit = 0;
        for (int i = 0; i < 4; i++) m_ipivp[i] = 32'h8000_0000;
        for (int i = 0; i < NCPU; i++) begin
            m_prio[i] = 4'hF; m_sa[i] = 0; m_sb[i] = 0;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 unmapped, 1 global, 2 bank; tag names the requirement
    task automatic classify(input logic [17:0] a, input int rq,
                            output int kind, output int cpu, output int off, output string tag);
        kind = 0; cpu = 0; off = 0; tag = "R2";
        if (a[3:0] != 0) begin
            tag = "R1";
        end else if (a[17]) begin
            off = int'(a[11:0]); cpu = int'(a[16:12]);
            if (cpu < NCPU && off >= 'h40 && off <= 'hB0) begin kind = 2; tag = "R4"; end
        end else if (a[16:13] == 0) begin
            off = int'(a[12:0]);
            if (off >= 'h40 && off <= 'hB0) begin
                if (rq < NCPU) begin kind = 2; cpu = rq; tag = "R5"; end
            end else begin
                case (off)
                    'h1000, 'h1080: begin kind = 1; tag = "R6"; end
                    'h1020: begin kind = 1; tag = "R7"; end
                    'h1090: begin kind = 1; tag = "R8"; end
                    'h10A0, 'h10B0, 'h10C0, 'h10D0: begin kind = 1; tag = "R10"; end
                    'h10E0, 'h10F0: begin kind = 1; tag = "R9"; end
                    default: kind = 0;
                endcase
            end
        end
    endtask

    task automatic exp_read(input logic [17:0] a, input int rq, output logic [31:0] v, output string tag);
        int kind, cpu, off;
        classify(a, rq, kind, cpu, off, tag);
        v = 32'hFFFF_FFFF;
        if (kind == 2) begin
            if (off <= 'h70) v = 0;
            else if (off == 'h80) v = {28'h0, m_prio[cpu]};
            else if (off == 'h90) v = 32'(cpu);
            else if (off == 'hA0) v = m_sa[cpu];
            else v = m_sb[cpu];
        end else if (kind == 1) begin
            case (off)
                'h1000: v = 32'(((NCPU - 1) << 8) | 4);
                'h1020: v = m_gcfg;
                'h1080: v = VID;
                'h1090: v = 0;
                'h10E0: v = {24'h0, m_spur};
                'h10F0: v = m_tfreq;
                default: v = m_ipivp[(off - 'h10A0) >> 4];
            endcase
        end
    endtask

    task automatic model_write(input logic [17:0] a, input logic [31:0] d, input int rq,
                               output bit e_ipi, output int e_src, output int e_num,
                               output logic [NCPU-1:0] e_dest, output bit e_crst);
        int kind, cpu, off;
        string tag;
        classify(a, rq, kind, cpu, off, tag);
        e_ipi = 0; e_src = 0; e_num = 0; e_dest = 0; e_crst = 0;
        if (kind == 2) begin
            if (off <= 'h70) begin
                e_ipi = 1; e_src = cpu; e_num = (off - 'h40) >> 4; e_dest = d[NCPU-1:0];
            end else if (off == 'h80) m_prio[cpu] = d[3:0];
            else if (off == 'hA0) m_sa[cpu] = d;
            else if (off == 'hB0) m_sb[cpu] = d;
        end else if (kind == 1) begin
            case (off)
                'h1020: begin m_gcfg = d & 32'h7FFF_FFFF; e_crst = d[31]; end
                'h1090: m_pinit = d[NCPU-1:0];
                'h10A0, 'h10B0, 'h10C0, 'h10D0: m_ipivp[(off - 'h10A0) >> 4] = d;
                'h10E0: m_spur = d[7:0];
                'h10F0: m_tfreq = d;
                default: ;
            endcase
        end
    endtask

    task automatic access(input bit wr, input logic [17:0] a, input logic [31:0] d, input int rq);
        logic [31:0] er;
        string tag;
        bit e_ipi, e_crst;
        int e_src, e_num;
        logic [NCPU-1:0] e_dest;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_cpu = 5'(rq);
        exp_read(a, rq, er, tag);
        if (wr) model_write(a, d, rq, e_ipi, e_src, e_num, e_dest, e_crst);
        else begin e_ipi = 0; e_src = 0; e_num = 0; e_dest = 0; e_crst = 0; end
        @(negedge clk);
        req_valid = 0; req_write = 0;
        if (!wr) begin
            chk({"R3 ", tag}, 32'(rsp_valid), 1);
            chk(tag, rsp_rdata, er);
        end else begin
            chk("R3 write", 32'(rsp_valid), 0);
        end
        chk("R11 ipi_valid", 32'(ipi_valid), 32'(e_ipi));
        if (e_ipi) begin
            chk("R11 ipi_src", 32'(ipi_src), 32'(e_src));
            chk("R11 ipi_num", 32'(ipi_num), 32'(e_num));
            chk("R11 ipi_dest", 32'(ipi_dest), 32'(e_dest));
        end
        chk("R7 ctrl_reset", 32'(ctrl_reset), 32'(e_crst));
        chk("R8 cpu_reset", 32'(cpu_reset), 32'(m_pinit));
    endtask

    function automatic logic [17:0] rand_addr();
        case ($urandom % 6)
            0: return 18'h01000 | 18'(($urandom % 16) << 4);
            1: return 18'(($urandom % 16) << 4);
            2: return {1'b1, 5'($urandom % 6), 12'(($urandom % 16) << 4)};
            3: return 18'($urandom);
            4: return 18'h01000 | 18'(($urandom % 16) << 4) | 18'($urandom % 16);
            default: return 18'h03090;
        endcase
    endfunction

    initial begin
        #(10 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R13 reset values of all output lines
        chk("R13 ctrl_reset", 32'(ctrl_reset), 0);
        chk("R13 cpu_reset", 32'(cpu_reset), 0);
        chk("R13 ipi_valid", 32'(ipi_valid), 0);
        chk("R13 rsp_valid", 32'(rsp_valid), 0);
        // R13 register reset values
        foreach (m_ipivp[i]) access(0, 18'h010A0 + 18'(i * 16), 0, 0);
        access(0, 18'h010E0, 0, 0);
        access(0, 18'h01020, 0, 1);
        access(0, 18'h20080, 0, 0);
        // R6 constant words, writes ignored
        access(1, 18'h01000, 32'hDEAD_BEEF, 0);
        access(0, 18'h01000, 0, 0);
        access(1, 18'h01080, 32'h1234_5678, 0);
        access(0, 18'h01080, 0, 3);
        // R5 shadow identity per requester; R2 out-of-range requester
        for (int c = 0; c < NCPU + 2; c++) access(0, 18'h00090, 0, c);
        // R4 explicit identity, including out-of-range index
        for (int c = 0; c < NCPU + 2; c++) access(0, {1'b1, 5'(c), 12'h090}, 0, 0);
        // R12 write via shadow, read via explicit region
        access(1, 18'h00080, 32'h0000_0FF3, 2);
        access(0, {1'b1, 5'd2, 12'h080}, 0, 0);
        access(1, {1'b1, 5'd1, 12'h0A0}, 32'hCAFE_0001, 3);
        access(0, 18'h000A0, 0, 1);
        access(0, 18'h000A0, 0, 0);
        // R7 reset request and masked store
        access(1, 18'h01020, 32'h8000_00AB, 0);
        access(0, 18'h01020, 0, 0);
        // R8 processor-init edges
        access(1, 18'h01090, 32'h5, 0);
        access(1, 18'h01090, 32'h7, 0);
        access(1, 18'h01090, 32'h2, 0);
        access(0, 18'h01090, 0, 0);
        access(1, 18'h01090, 32'h0, 0);
        // R9 spurious width and timer word
        access(1, 18'h010E0, 32'hFFFF_1234, 0);
        access(0, 18'h010E0, 0, 0);
        access(1, 18'h010F0, 32'h0BAD_F00D, 0);
        // R1 misaligned write ignored, misaligned read all ones
        access(1, 18'h010F4, 32'h1111_1111, 0);
        access(0, 18'h010F0, 0, 0);
        access(0, 18'h010F4, 0, 0);
        // R10 IPI vector/priority words
        access(1, 18'h010C0, 32'h0004_0055, 0);
        access(0, 18'h010C0, 0, 0);
        // R11 dispatch via shadow and explicit region
        access(1, 18'h00060, 32'h0000_000B, 3);
        access(1, {1'b1, 5'd0, 12'h070}, 32'h0000_0006, 2);
        access(0, 18'h00050, 0, 1);
        // R2 unmapped aligned offsets
        access(1, 18'h01040, 32'hFFFF_FFFF, 0);
        access(0, 18'h01040, 0, 0);
        access(0, 18'h03090, 0, 0);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            access(1'($urandom % 2), rand_addr(), $urandom, int'($urandom % 6));
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule